// File: doc/BRIEF.md
# UART Register Front End

This block is the register side of a UART peripheral on a simple 16-bit memory-mapped bus. It holds the baud divisor bytes, the global, line and modem control bytes, a scratch byte, the interrupt-enable byte, and the sticky line and modem status bytes. The serial shift engines, the baud generator, the FIFOs and DMA sit outside. They connect through a byte strobe toward the transmitter, a valid/pop handshake from the receiver, and a few live status inputs.

The bus is single-cycle. The requester holds `bus_sel` for one cycle with a byte address, an access size, a write flag and write data. Read data, the error flag and all side-effect strobes (`tx_load`, `tx_irq`, `rx_pop`) are registered, so they appear in the cycle after the access. The interrupt enable is never written directly. One address ORs ones into it and another clears the bits written as one. Several status bits are sticky and are cleared by writing one to them.

Top module: `serial_reg_front`

## Requirements
- R1: Registers sit on a 4-byte stride at byte offsets 0x00 divisor low, 0x04 divisor high, 0x08 global control, 0x0C line control, 0x10 modem control, 0x14 line status, 0x18 modem status, 0x1C scratch, 0x20 enable-set, 0x24 enable-clear, 0x28 transmit holding and 0x2C receive buffer. Access size is encoded as 0 for byte, 1 for 16-bit and 2 for 32-bit. An access that is not 16-bit, that is not 4-byte aligned, or that is at offset 0x30 or above raises `bus_err` in the next cycle.
- R2: After reset, divisor low reads 0x0001, line status reads 0x0060 when all live status inputs are low, and every other register reads 0x0000.
- R3: Divisor low/high, global, line and modem control and scratch keep only the low 8 bits of a write. Every read returns zero in bits 15:8.
- R4: A write to enable-set ORs the written byte into the interrupt enable. A write to enable-clear clears the enable bits written as one. A read of either address returns the current enable value.
- R5: Line status bits are: 0 data ready, 1 to 4 line errors, 5 holding empty, 6 transmitter empty. A write to line status clears the stored bits 0, 5 and 6 where the data is one. All other bits are left unchanged.
- R6: A read of line status ORs the live inputs (`rx_valid` into bit 0, `stat_line_err[3:0]` into bits 4:1, `stat_hold_empty` into bit 5, `stat_tx_empty` into bit 6) into the stored value, returns the result, and keeps it stored after the inputs drop.
- R7: Modem status bit 0 is set, and stays set, when the synchronised `cts` input changes. Writing one to bit 0 clears it, and other written bits have no effect. Bit 4 reads the synchronised `cts` level.
- R8: A write to transmit holding pulses `tx_load` for one cycle with the low byte on `tx_data`. `tx_irq` pulses in the same cycle only when enable bit 1 is set. Reading transmit holding returns the last byte written.
- R9: A read of the receive buffer while `rx_valid` is high returns `rx_data` and pulses `rx_pop` once. With `rx_valid` low it returns the last received byte and does not pop. Writes to the receive buffer change nothing and do not pop.
- R10: An invalid access changes no register, returns zero read data and raises no `tx_load` or `rx_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the block |
| bus_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Invalid-access flag, the cycle after the access |
| tx_data | output | 8 | Byte handed to the transmitter |
| tx_load | output | 1 | One-cycle strobe: `tx_data` is valid |
| tx_irq | output | 1 | Transmit interrupt request pulse |
| rx_data | input | 8 | Byte offered by the receiver |
| rx_valid | input | 1 | Receiver holds a byte (data ready) |
| rx_pop | output | 1 | One-cycle strobe: the byte was consumed |
| stat_tx_empty | input | 1 | Live transmitter-empty status |
| stat_hold_empty | input | 1 | Live holding-register-empty status |
| stat_line_err | input | 4 | Live line error flags |
| cts | input | 1 | Clear-to-send level, asynchronous |

## Verification
Some properties are checked on every cycle by assertions: the error response to a wrong access size, zero upper read bytes, an interrupt pulse only together with a load strobe, no pop on a write or a rejected access, line status bits that only a write can lower, a W1C write that actually clears the masked bits, and a modem-change flag that holds until it is cleared. Other behaviour can only be shown by the bench scenarios. These include the reset values, the exact byte kept in each plain register, the set and clear arithmetic of the enable, which line status bits survive a clear-all write, the merged value a status read returns, and the receive buffer keeping its last byte when the receiver is empty.

// File: rtl/serial_rf_pkg.sv
package serial_rf_pkg;
   localparam int NUM_REGS    = 12;
   localparam int IX_DIVLO    = 0;
   localparam int IX_DIVHI    = 1;
   localparam int IX_GCTL     = 2;
   localparam int IX_LCTL     = 3;
   localparam int IX_MCTL     = 4;
   localparam int IX_LSTAT    = 5;
   localparam int IX_MSTAT    = 6;
   localparam int IX_SCRATCH  = 7;
   localparam int IX_IEN_SET  = 8;
   localparam int IX_IEN_CLR  = 9;
   localparam int IX_TXHOLD   = 10;
   localparam int IX_RXBUF    = 11;

   localparam int NUM_PLAIN   = 6;
   localparam int PL_DIVLO    = 0;
   localparam int PL_DIVHI    = 1;
   localparam int PL_GCTL     = 2;
   localparam int PL_LCTL     = 3;
   localparam int PL_MCTL     = 4;
   localparam int PL_SCRATCH  = 5;

   localparam logic [1:0] SZ_HALF = 2'b01;

   localparam int LS_READY    = 0;
   localparam int LS_HOLD_EMP = 5;
   localparam int LS_TX_EMP   = 6;
   localparam int MS_CTS_CHG  = 0;
   localparam int MS_CTS_LVL  = 4;
   localparam int IE_TX_EMPTY = 1;
endpackage

// File: rtl/rf_addr_decode.sv
module rf_addr_decode #(
   parameter int ADDR_W     = 6,
   parameter int STRIDE_LOG = 2,
   parameter int NUM_REGS   = 12,
   localparam int IDX_W     = $clog2(NUM_REGS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [1:0]        size_ok_code,
   output logic [IDX_W-1:0]  idx,
   output logic              ok
);
   localparam int TOP_LSB = STRIDE_LOG + IDX_W;

   logic upper_zero;
   logic aligned;

   if (ADDR_W < TOP_LSB) begin : g_bad_width
      $error("rf_addr_decode: ADDR_W too small for the register map");
   end

   if (ADDR_W > TOP_LSB) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:TOP_LSB] == '0);
   end else begin : g_no_upper
      assign upper_zero = 1'b1;
   end

   if (STRIDE_LOG > 0) begin : g_align
      assign aligned = (addr[STRIDE_LOG-1:0] == '0);
   end else begin : g_no_align
      assign aligned = 1'b1;
   end

   assign idx = addr[STRIDE_LOG +: IDX_W];
   assign ok  = upper_zero && aligned && (size == size_ok_code)
                && (int'(idx) < NUM_REGS);
endmodule

// File: rtl/rf_ctrl_regs.sv
module rf_ctrl_regs #(
   parameter int          REG_W     = 8,
   parameter int          NUM_PLAIN = 6,
   parameter logic [7:0]  LO_RESET  = 8'h01
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PLAIN-1:0]  plain_wr,
   input  logic                  ien_set,
   input  logic                  ien_clr,
   input  logic [REG_W-1:0]      wdata,
   output logic [REG_W-1:0]      plain_q [NUM_PLAIN],
   output logic [REG_W-1:0]      ien_q
);
   if (NUM_PLAIN < 1) begin : g_bad_count
      $error("rf_ctrl_regs: NUM_PLAIN must be at least 1");
   end

   for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
      localparam logic [REG_W-1:0] RST = (g == 0) ? REG_W'(LO_RESET) : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           plain_q[g] <= RST;
         else if (plain_wr[g]) plain_q[g] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ien_q <= '0;
      else if (ien_set) ien_q <= ien_q | wdata;
      else if (ien_clr) ien_q <= ien_q & ~wdata;
   end

   p_ien_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ien_set |=> ((ien_q & $past(wdata)) == $past(wdata)));
   p_ien_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ien_clr && !ien_set |=> ((ien_q & $past(wdata)) == '0));
endmodule

// File: rtl/rf_status_regs.sv
module rf_status_regs #(
   parameter int          REG_W     = 8,
   parameter logic [7:0]  LS_RESET  = 8'h60,
   parameter logic [7:0]  LS_W1C    = 8'h61,
   parameter int          CHG_BIT   = 0,
   parameter int          LVL_BIT   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ls_rd,
   input  logic              ls_wr,
   input  logic              ms_wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [REG_W-1:0]  ls_live,
   input  logic              cts_async,
   output logic [REG_W-1:0]  ls_view,
   output logic [REG_W-1:0]  ms_view
);
   localparam logic [REG_W-1:0] W1C_MASK = REG_W'(LS_W1C);

   if (CHG_BIT >= REG_W || LVL_BIT >= REG_W) begin : g_bad_bits
      $error("rf_status_regs: modem bit positions exceed REG_W");
   end

   logic [REG_W-1:0] ls_q;
   logic             cts_s, cts_d, chg_q;

   assign ls_view = ls_q | ls_live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ls_q <= REG_W'(LS_RESET);
      else if (ls_rd) ls_q <= ls_q | ls_live;
      else if (ls_wr) ls_q <= ls_q & ~(wdata & W1C_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cts_s <= 1'b0;
         cts_d <= 1'b0;
         chg_q <= 1'b0;
      end else begin
         cts_s <= cts_async;
         cts_d <= cts_s;
         if (cts_s != cts_d)              chg_q <= 1'b1;
         else if (ms_wr && wdata[CHG_BIT]) chg_q <= 1'b0;
      end
   end

   always_comb begin
      ms_view          = '0;
      ms_view[CHG_BIT] = chg_q;
      ms_view[LVL_BIT] = cts_s;
   end

   p_ls_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ls_wr && !ls_rd |=> ((ls_q & $past(wdata) & W1C_MASK) == '0));
   p_ls_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ls_wr |=> ((ls_q & $past(ls_q)) == $past(ls_q)));
   p_ms_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chg_q && !(ms_wr && wdata[CHG_BIT]) |=> chg_q);
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
   import serial_rf_pkg::*;
#(
   parameter int          ADDR_W     = 6,
   parameter int          DATA_W     = 16,
   parameter int          REG_W      = 8,
   parameter int          STRIDE_LOG = 2,
   parameter int          ERR_W      = 4,
   parameter logic [7:0]  DIVLO_RST  = 8'h01,
   parameter logic [7:0]  LSTAT_RST  = 8'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   output logic [REG_W-1:0]  tx_data,
   output logic              tx_load,
   output logic              tx_irq,
   input  logic [REG_W-1:0]  rx_data,
   input  logic              rx_valid,
   output logic              rx_pop,
   input  logic              stat_tx_empty,
   input  logic              stat_hold_empty,
   input  logic [ERR_W-1:0]  stat_line_err,
   input  logic              cts
);
   localparam int IDX_W  = $clog2(NUM_REGS);
   localparam int HI_W   = DATA_W - REG_W;
   localparam logic [7:0] LS_MASK = 8'((1 << LS_READY) | (1 << LS_HOLD_EMP) | (1 << LS_TX_EMP));

   if (REG_W >= DATA_W) begin : g_bad_reg_w
      $error("serial_reg_front: REG_W must be narrower than DATA_W");
   end
   if (ERR_W != LS_HOLD_EMP - LS_READY - 1) begin : g_bad_err_w
      $error("serial_reg_front: ERR_W must fill the bits between ready and hold-empty");
   end
   if (REG_W <= LS_TX_EMP) begin : g_bad_ls_w
      $error("serial_reg_front: REG_W too narrow for line status");
   end

   logic [IDX_W-1:0] idx;
   logic             dec_ok;

   rf_addr_decode #(
      .ADDR_W(ADDR_W), .STRIDE_LOG(STRIDE_LOG), .NUM_REGS(NUM_REGS)
   ) u_dec (
      .addr(bus_addr), .size(bus_size), .size_ok_code(SZ_HALF),
      .idx(idx), .ok(dec_ok)
   );

   logic acc_ok, wr_ok, rd_ok;
   assign acc_ok = bus_sel && dec_ok;
   assign wr_ok  = acc_ok && bus_wr;
   assign rd_ok  = acc_ok && !bus_wr;

   logic [NUM_REGS-1:0] hit;
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
      assign hit[g] = (int'(idx) == g);
   end

   logic [NUM_PLAIN-1:0] plain_wr;
   assign plain_wr[PL_DIVLO]   = wr_ok && hit[IX_DIVLO];
   assign plain_wr[PL_DIVHI]   = wr_ok && hit[IX_DIVHI];
   assign plain_wr[PL_GCTL]    = wr_ok && hit[IX_GCTL];
   assign plain_wr[PL_LCTL]    = wr_ok && hit[IX_LCTL];
   assign plain_wr[PL_MCTL]    = wr_ok && hit[IX_MCTL];
   assign plain_wr[PL_SCRATCH] = wr_ok && hit[IX_SCRATCH];

   logic [REG_W-1:0] wbyte;
   assign wbyte = bus_wdata[REG_W-1:0];

   logic [REG_W-1:0] plain_q [NUM_PLAIN];
   logic [REG_W-1:0] ien_q;

   rf_ctrl_regs #(
      .REG_W(REG_W), .NUM_PLAIN(NUM_PLAIN), .LO_RESET(DIVLO_RST)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .plain_wr(plain_wr),
      .ien_set(wr_ok && hit[IX_IEN_SET]), .ien_clr(wr_ok && hit[IX_IEN_CLR]),
      .wdata(wbyte), .plain_q(plain_q), .ien_q(ien_q)
   );

   logic [REG_W-1:0] ls_live, ls_view, ms_view;
   always_comb begin
      ls_live = '0;
      ls_live[LS_READY]                  = rx_valid;
      ls_live[LS_READY+1 +: ERR_W]       = stat_line_err;
      ls_live[LS_HOLD_EMP]               = stat_hold_empty;
      ls_live[LS_TX_EMP]                 = stat_tx_empty;
   end

   rf_status_regs #(
      .REG_W(REG_W), .LS_RESET(LSTAT_RST), .LS_W1C(LS_MASK),
      .CHG_BIT(MS_CTS_CHG), .LVL_BIT(MS_CTS_LVL)
   ) u_stat (
      .clk(clk), .rst_n(rst_n),
      .ls_rd(rd_ok && hit[IX_LSTAT]), .ls_wr(wr_ok && hit[IX_LSTAT]),
      .ms_wr(wr_ok && hit[IX_MSTAT]), .wdata(wbyte),
      .ls_live(ls_live), .cts_async(cts),
      .ls_view(ls_view), .ms_view(ms_view)
   );

   logic [REG_W-1:0] thr_q, rbr_q;
   logic             take_rx;
   assign take_rx = rd_ok && hit[IX_RXBUF] && rx_valid;

   logic [REG_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      unique case (int'(idx))
         IX_DIVLO:   rd_mux = plain_q[PL_DIVLO];
         IX_DIVHI:   rd_mux = plain_q[PL_DIVHI];
         IX_GCTL:    rd_mux = plain_q[PL_GCTL];
         IX_LCTL:    rd_mux = plain_q[PL_LCTL];
         IX_MCTL:    rd_mux = plain_q[PL_MCTL];
         IX_LSTAT:   rd_mux = ls_view;
         IX_MSTAT:   rd_mux = ms_view;
         IX_SCRATCH: rd_mux = plain_q[PL_SCRATCH];
         IX_IEN_SET,
         IX_IEN_CLR: rd_mux = ien_q;
         IX_TXHOLD:  rd_mux = thr_q;
         IX_RXBUF:   rd_mux = rx_valid ? rx_data : rbr_q;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
         tx_data   <= '0;
         tx_load   <= 1'b0;
         tx_irq    <= 1'b0;
         rx_pop    <= 1'b0;
         thr_q     <= '0;
         rbr_q     <= '0;
      end else begin
         bus_rdata <= rd_ok ? {{HI_W{1'b0}}, rd_mux} : '0;
         bus_err   <= bus_sel && !dec_ok;
         tx_load   <= wr_ok && hit[IX_TXHOLD];
         tx_irq    <= wr_ok && hit[IX_TXHOLD] && ien_q[IE_TX_EMPTY];
         rx_pop    <= take_rx;
         if (wr_ok && hit[IX_TXHOLD]) begin
            thr_q   <= wbyte;
            tx_data <= wbyte;
         end
         if (take_rx) rbr_q <= rx_data;
      end
   end

   p_err_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && (bus_size != SZ_HALF) |=> bus_err);
   p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:REG_W] == '0);
   p_irq_with_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> tx_load);
   p_no_pop_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && bus_wr |=> !rx_pop);
   p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (!tx_load && !rx_pop && bus_rdata == '0));
endmodule

// File: tb/sim_serial_reg_front.sv
`timescale 1ns/1ps
module sim_serial_reg_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'd1;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_err;
   logic [7:0]  tx_data;
   logic        tx_load, tx_irq;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0;
   logic        rx_pop;
   logic        stat_tx_empty = 1'b0, stat_hold_empty = 1'b0;
   logic [3:0]  stat_line_err = '0;
   logic        cts = 1'b0;

   int total = 0;
   int bad = 0;

   logic [15:0] r_data;
   logic        r_err, r_load, r_irq, r_pop;
   logic [7:0]  r_txd;

   always #2 clk = ~clk;

   serial_reg_front u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .tx_data(tx_data),
      .tx_load(tx_load), .tx_irq(tx_irq), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_pop(rx_pop), .stat_tx_empty(stat_tx_empty),
      .stat_hold_empty(stat_hold_empty), .stat_line_err(stat_line_err),
      .cts(cts)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic wr, input logic [5:0] addr, input logic [1:0] size,
                      input logic [15:0] wdata);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_size = size; bus_wdata = wdata;
      @(negedge clk);
      bus_sel = 1'b0;
      r_data = bus_rdata; r_err = bus_err; r_load = tx_load;
      r_irq = tx_irq; r_pop = rx_pop; r_txd = tx_data;
   endtask

   // {wr, byte address, write data, expected read}
   localparam logic [38:0] VEC [12] = '{
      {1'b1, 6'h00, 16'hAB5C, 16'h0000}, {1'b0, 6'h00, 16'h0000, 16'h005C},
      {1'b1, 6'h04, 16'h1234, 16'h0000}, {1'b0, 6'h04, 16'h0000, 16'h0034},
      {1'b1, 6'h08, 16'hFFFF, 16'h0000}, {1'b0, 6'h08, 16'h0000, 16'h00FF},
      {1'b1, 6'h0C, 16'h0003, 16'h0000}, {1'b0, 6'h0C, 16'h0000, 16'h0003},
      {1'b1, 6'h10, 16'h8010, 16'h0000}, {1'b0, 6'h10, 16'h0000, 16'h0010},
      {1'b1, 6'h1C, 16'h77A5, 16'h0000}, {1'b0, 6'h1C, 16'h0000, 16'h00A5}
   };

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset values
      acc(0, 6'h00, 1, 0); check("R2 divisor low reset", r_data, 16'h0001);
      acc(0, 6'h14, 1, 0); check("R2 line status reset", r_data, 16'h0060);
      acc(0, 6'h18, 1, 0); check("R2 modem status reset", r_data, 16'h0000);
      acc(0, 6'h20, 1, 0); check("R2 enable reset", r_data, 16'h0000);
      acc(0, 6'h2C, 1, 0); check("R2 receive buffer reset", r_data, 16'h0000);

      // R3 plain storage table walk
      for (int i = 0; i < 12; i++) begin
         acc(VEC[i][38], VEC[i][37:32], 1, VEC[i][31:16]);
         if (!VEC[i][38]) check("R3 plain register readback", r_data, VEC[i][15:0]);
         check("R1 valid access no error", {15'd0, r_err}, 16'd0);
      end

      // R4 enable set / clear
      acc(1, 6'h20, 1, 16'h0005);
      acc(0, 6'h20, 1, 0); check("R4 read via set", r_data, 16'h0005);
      acc(1, 6'h20, 1, 16'h0002);
      acc(0, 6'h24, 1, 0); check("R4 read via clear", r_data, 16'h0007);
      acc(1, 6'h24, 1, 16'h0004);
      acc(0, 6'h20, 1, 0); check("R4 clear bit 2", r_data, 16'h0003);

      // R8 transmit with interrupt enabled (bit 1 set)
      acc(1, 6'h28, 1, 16'h01C3);
      check("R8 load strobe", {15'd0, r_load}, 16'd1);
      check("R8 tx byte", {8'd0, r_txd}, 16'h00C3);
      check("R8 irq when enabled", {15'd0, r_irq}, 16'd1);
      acc(1, 6'h24, 1, 16'h0002);
      acc(1, 6'h28, 1, 16'h0042);
      check("R8 load strobe again", {15'd0, r_load}, 16'd1);
      check("R8 no irq when disabled", {15'd0, r_irq}, 16'd0);
      acc(0, 6'h28, 1, 0); check("R8 holding readback", r_data, 16'h0042);
      check("R8 load only on write", {15'd0, r_load}, 16'd0);

      // R5 / R6 line status
      acc(1, 6'h14, 1, 16'h00FF);
      acc(0, 6'h14, 1, 0); check("R5 clear both empty flags", r_data, 16'h0000);
      @(negedge clk);
      stat_tx_empty = 1'b1; rx_valid = 1'b1; rx_data = 8'h5A; stat_line_err = 4'b0101;
      acc(0, 6'h14, 1, 0); check("R6 merge live status", r_data, 16'h004B);
      @(negedge clk);
      stat_tx_empty = 1'b0; rx_valid = 1'b0; stat_line_err = 4'b0000;
      acc(0, 6'h14, 1, 0); check("R6 merged value stays", r_data, 16'h004B);
      acc(1, 6'h14, 1, 16'h00FF);
      acc(0, 6'h14, 1, 0); check("R5 only bits 0,5,6 clear", r_data, 16'h000A);

      // R7 modem status
      @(negedge clk); cts = 1'b1;
      repeat (4) @(negedge clk);
      acc(0, 6'h18, 1, 0); check("R7 change and level", r_data, 16'h0011);
      acc(1, 6'h18, 1, 16'h00FE);
      acc(0, 6'h18, 1, 0); check("R7 other bits no clear", r_data, 16'h0011);
      acc(1, 6'h18, 1, 16'h0001);
      acc(0, 6'h18, 1, 0); check("R7 w1c change", r_data, 16'h0010);
      @(negedge clk); cts = 1'b0;
      repeat (4) @(negedge clk);
      acc(0, 6'h18, 1, 0); check("R7 change on fall", r_data, 16'h0001);

      // R9 receive buffer
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'hC7;
      acc(0, 6'h2C, 1, 0);
      check("R9 read byte", r_data, 16'h00C7);
      check("R9 pop pulse", {15'd0, r_pop}, 16'd1);
      @(negedge clk); rx_valid = 1'b0; rx_data = 8'h11;
      acc(0, 6'h2C, 1, 0);
      check("R9 hold last byte", r_data, 16'h00C7);
      check("R9 no pop when empty", {15'd0, r_pop}, 16'd0);
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'h33;
      acc(1, 6'h2C, 1, 16'h0077);
      check("R9 write no pop", {15'd0, r_pop}, 16'd0);
      @(negedge clk); rx_valid = 1'b0;
      acc(0, 6'h2C, 1, 0);
      check("R9 write ignored", r_data, 16'h00C7);

      // R1 / R10 invalid accesses
      acc(1, 6'h1C, 0, 16'h0011);
      check("R1 byte access error", {15'd0, r_err}, 16'd1);
      acc(0, 6'h1C, 1, 0); check("R10 scratch unchanged", r_data, 16'h00A5);
      acc(0, 6'h1C, 2, 0);
      check("R1 word access error", {15'd0, r_err}, 16'd1);
      check("R10 zero data on error", r_data, 16'h0000);
      acc(0, 6'h30, 1, 0);
      check("R1 out of map error", {15'd0, r_err}, 16'd1);
      acc(1, 6'h2A, 1, 16'h0099);
      check("R1 unaligned error", {15'd0, r_err}, 16'd1);
      check("R10 no load on error", {15'd0, r_load}, 16'd0);
      acc(0, 6'h28, 1, 0); check("R10 holding unchanged", r_data, 16'h0042);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule